// File: doc/BRIEF.md
# Glitch-free dual clock multiplexer

This block picks one of two free-running clocks and drives it onto a single clock output. A change of choice never produces a runt pulse. The block first lets go of the clock it is driving, on that clock's own switching edge, and holds the output at a fixed park level. It then waits for the newly chosen clock's switching edge before it lets that clock through.

Each input is requested by a pair of lines, a select and an enable, and counts only when both are high. The select line may change at any time. The enable line is meant to be timed against its own clock. If both inputs are requested, input 0 wins. If neither is requested, the output rests at the park level.

A parameter chooses the polarity:
- Park low: switching happens on falling edges.
- Park high: switching happens on rising edges.

A per-input ignore flag gives up edge detection when leaving that input, so the output departs at the instant the request drops. Two preselect parameters decide which input drives the output during reset and straight after it.

Top module: `cmux_glitchfree`

## Requirements
- R1: Input n is requested only when its select line and its enable line are both 1. Any other combination of the pair leaves that input unrequested.
- R2: With PARK_HIGH=0, once the request for the driving input drops, the output goes on following that clock. If the drop falls in a high phase, the output is still 1 within that phase. The clock is let go only on one of its falling edges, so the output is then low.
- R3: A newly requested input gets the output only after the old input has been let go. Until then the output stays at the park level. The new clock is passed from one of its own switching edges onward (falling edges when PARK_HIGH=0).
- R4: With PARK_HIGH=1, the hand-over happens on rising edges and the output is held at 1 between the two clocks.
- R5: With ign0_i=1, the output leaves input 0 at the instant its request drops and takes the park level at once. ign1_i=1 does the same for input 1.
- R6: While arst_ni=0, and straight after it rises, the output follows the preselected input. PRESEL0=1 picks input 0. Otherwise PRESEL1=1 picks input 1. If both are set, input 0 is picked.
- R7: When no input is enabled, the output sits at the park level: 0 for PARK_HIGH=0 and 1 for PARK_HIGH=1.
- R8: At most one input is enabled onto the output at any time.
- R9: When both inputs are requested, input 0 drives the output.
- R10: While both ignore flags are 0, no high or low pulse on clk_o is shorter than the shorter half-period of the two input clocks, whatever the timing of the request changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk0_i | input | 1 | Input clock 0 |
| clk1_i | input | 1 | Input clock 1 |
| arst_ni | input | 1 | Asynchronous reset, active low |
| sel0_i | input | 1 | Select line of input 0, may be asynchronous |
| en0_i | input | 1 | Enable line of input 0, timed against clk0_i |
| sel1_i | input | 1 | Select line of input 1, may be asynchronous |
| en1_i | input | 1 | Enable line of input 1, timed against clk1_i |
| ign0_i | input | 1 | Leave input 0 at once when its request drops |
| ign1_i | input | 1 | Leave input 1 at once when its request drops |
| clk_o | output | 1 | Multiplexed clock output |

## Verification
Two instances share one set of stimulus: one parks low with input 0 preselected, the other parks high with input 1 preselected.

Each request pattern is held long enough to settle. The output is then sampled in both phases of the expected clock. This separates a correct choice from a wrong input, from a stuck park level, and from the wrong polarity.

The select-only and enable-only patterns show that a half-asserted pair is not a request. The both-requested pattern shows the priority.

Drops placed in the middle of a high phase tell the edge-waiting release apart from the immediate release with the ignore flag set. A long run of changes at random times, with two unrelated clock periods, is watched for any output pulse shorter than the faster clock's half-period.

// File: rtl/cmux_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the glitch-free clock multiplexer.
package cmux_pkg;

    // Which edge of an input clock moves the enable state.
    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } sw_edge_e;

    // An input is requested only when both lines of its pair are high.
    function automatic logic pair_req(input logic sel, input logic en);
        return sel & en;
    endfunction

endpackage

// File: rtl/cmux_edge_clk.sv
`timescale 1ns/1ps
// Produces the clock whose rising edge is the switching edge of one input.
module cmux_edge_clk
    import cmux_pkg::*;
#(
    parameter sw_edge_e EDGE = EDGE_FALL
) (
    input  logic clk_i,
    output logic sw_clk_o
);

    generate
        if (EDGE == EDGE_RISE) begin : g_rise
            assign sw_clk_o = clk_i;
        end else begin : g_fall
            assign sw_clk_o = ~clk_i;
        end
    endgenerate

endmodule

// File: rtl/cmux_req_arb.sv
`timescale 1ns/1ps
// Forms the per-input requests with input 0 priority, applies the ignore
// release and cross-couples the busy state of each domain into the other.
module cmux_req_arb
    import cmux_pkg::*;
#(
    parameter int unsigned NCLK = 2
) (
    input  logic [NCLK-1:0] sel_i,
    input  logic [NCLK-1:0] en_i,
    input  logic [NCLK-1:0] ign_i,
    input  logic [NCLK-1:0] busy_q_i,
    input  logic [NCLK-1:0] act_q_i,
    output logic [NCLK-1:0] want_o,
    output logic [NCLK-1:0] act_eff_o
);

    logic [NCLK-1:0] req;
    logic [NCLK-1:0] rel;
    logic [NCLK-1:0] busy_eff;

    always_comb begin
        // R1 / R9: pair decode, input 0 wins when both are requested
        req[0] = pair_req(sel_i[0], en_i[0]);
        req[1] = pair_req(sel_i[1], en_i[1]) & ~req[0];
        // R5: an ignore flag releases its input as soon as its request drops
        rel       = ign_i & ~req;
        busy_eff  = busy_q_i & ~rel;
        act_eff_o = act_q_i & ~rel;
        // R3 / R8: a domain may start only while the other one is fully idle
        want_o[0] = req[0] & ~busy_eff[1];
        want_o[1] = req[1] & ~busy_eff[0];
    end

endmodule

// File: rtl/cmux_domain.sv
`timescale 1ns/1ps
// One clock domain: a synchroniser chain clocked on the switching edge.
// The last stage is the enable flag of this input.
module cmux_domain #(
    parameter int unsigned STAGES = 2,
    parameter bit          PRESET = 1'b0
) (
    input  logic sw_clk_i,
    input  logic arst_ni,
    input  logic want_i,
    output logic act_o,
    output logic busy_o
);

    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] sync;
    } dom_state_t;

    dom_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.sync = {state_q.sync[LAST-1:0], want_i};
    end

    // R6: reset loads every stage from the preselect, bypassing the chain
    always_ff @(posedge sw_clk_i or negedge arst_ni) begin
        if (!arst_ni) begin
            state_q.sync <= {STAGES{PRESET}};
        end else begin
            state_q <= state_d;
        end
    end

    assign act_o  = state_q.sync[LAST];
    assign busy_o = |state_q.sync;

endmodule

// File: rtl/cmux_glitchfree.sv
`timescale 1ns/1ps
// Glitch-free two-input clock multiplexer.
module cmux_glitchfree
    import cmux_pkg::*;
#(
    parameter bit          PARK_HIGH = 1'b0,
    parameter bit          PRESEL0   = 1'b1,
    parameter bit          PRESEL1   = 1'b0,
    parameter int unsigned STAGES    = 2
) (
    input  logic clk0_i,
    input  logic clk1_i,
    input  logic arst_ni,
    input  logic sel0_i,
    input  logic en0_i,
    input  logic sel1_i,
    input  logic en1_i,
    input  logic ign0_i,
    input  logic ign1_i,
    output logic clk_o
);

    localparam int unsigned    NCLK    = 2;
    localparam sw_edge_e       SW_EDGE = sw_edge_e'(PARK_HIGH);
    localparam bit [NCLK-1:0]  PRESET  = {PRESEL1 & ~PRESEL0, PRESEL0};

    logic [NCLK-1:0] clk_in;
    logic [NCLK-1:0] sel;
    logic [NCLK-1:0] en;
    logic [NCLK-1:0] ign;
    logic [NCLK-1:0] sw_clk;
    logic [NCLK-1:0] want;
    logic [NCLK-1:0] act_q;
    logic [NCLK-1:0] busy_q;
    logic [NCLK-1:0] act_eff;

    assign clk_in = {clk1_i, clk0_i};
    assign sel    = {sel1_i, sel0_i};
    assign en     = {en1_i, en0_i};
    assign ign    = {ign1_i, ign0_i};

    cmux_req_arb #(.NCLK(NCLK)) u_arb (
        .sel_i     (sel),
        .en_i      (en),
        .ign_i     (ign),
        .busy_q_i  (busy_q),
        .act_q_i   (act_q),
        .want_o    (want),
        .act_eff_o (act_eff)
    );

    for (genvar g = 0; g < NCLK; g++) begin : g_dom
        cmux_edge_clk #(.EDGE(SW_EDGE)) u_edge (
            .clk_i    (clk_in[g]),
            .sw_clk_o (sw_clk[g])
        );

        cmux_domain #(.STAGES(STAGES), .PRESET(PRESET[g])) u_dom (
            .sw_clk_i (sw_clk[g]),
            .arst_ni  (arst_ni),
            .want_i   (want[g]),
            .act_o    (act_q[g]),
            .busy_o   (busy_q[g])
        );
    end

    // Enable flags change only while their clock sits at the park level,
    // so gating cannot cut a pulse short.
    generate
        if (PARK_HIGH) begin : g_park_high
            assign clk_o = ~|(~clk_in & act_eff);
        end else begin : g_park_low
            assign clk_o = |(clk_in & act_eff);
        end
    endgenerate

endmodule

// File: rtl/cmux_glitchfree_chk.sv
`timescale 1ns/1ps
// Properties of the clock multiplexer, attached by bind.
module cmux_glitchfree_chk #(
    parameter bit PARK_HIGH = 1'b0,
    parameter bit PRESEL0   = 1'b1,
    parameter bit PRESEL1   = 1'b0
) (
    input logic       arst_ni,
    input logic [1:0] sw_clk,
    input logic [1:0] act_q,
    input logic [1:0] act_eff,
    input logic       clk_o
);

    // R8: the two enable flags are never on together
    a_r8_exclusive_d0: assert property (@(posedge sw_clk[0]) disable iff (!arst_ni)
        !(act_eff[0] && act_eff[1]));
    a_r8_exclusive_d1: assert property (@(posedge sw_clk[1]) disable iff (!arst_ni)
        !(act_eff[0] && act_eff[1]));

    // R3: a domain turns on only if the other was off one switching edge before
    a_r3_wait_other_d0: assert property (@(posedge sw_clk[0]) disable iff (!arst_ni)
        $rose(act_q[0]) |-> !$past(act_eff[1]));
    a_r3_wait_other_d1: assert property (@(posedge sw_clk[1]) disable iff (!arst_ni)
        $rose(act_q[1]) |-> !$past(act_eff[0]));

    // R7: with nothing enabled the output rests at the park level
    a_r7_park_level: assert property (@(posedge sw_clk[0]) disable iff (!arst_ni)
        (!act_eff[0] && !act_eff[1]) |-> (clk_o == PARK_HIGH));

    // R6: leaving reset, the flags still hold the preselect
    a_r6_preset_d0: assert property (@(posedge sw_clk[0]) disable iff (!arst_ni)
        $rose(arst_ni) |-> (act_q[0] == PRESEL0));
    a_r6_preset_d1: assert property (@(posedge sw_clk[1]) disable iff (!arst_ni)
        $rose(arst_ni) |-> (act_q[1] == (PRESEL1 && !PRESEL0)));

endmodule

bind cmux_glitchfree cmux_glitchfree_chk #(
    .PARK_HIGH (PARK_HIGH),
    .PRESEL0   (PRESEL0),
    .PRESEL1   (PRESEL1)
) u_chk (
    .arst_ni (arst_ni),
    .sw_clk  (sw_clk),
    .act_q   (act_q),
    .act_eff (act_eff),
    .clk_o   (clk_o)
);

// File: tb/sim_cmux_glitchfree.sv
`timescale 1ns/1ps
module sim_cmux_glitchfree;

    logic clk0 = 1'b0;
    logic clk1 = 1'b0;
    logic arst_n = 1'b0;
    logic s0 = 1'b0, e0 = 1'b0, s1 = 1'b0, e1 = 1'b0;
    logic g0 = 1'b0, g1 = 1'b0;
    logic out0, out1;

    // 250 MHz primary clock, unrelated second clock
    always #2.0 clk0 = ~clk0;
    always #3.4 clk1 = ~clk1;

    // park low, input 0 preselected
    cmux_glitchfree u0 (
        .clk0_i(clk0), .clk1_i(clk1), .arst_ni(arst_n),
        .sel0_i(s0), .en0_i(e0), .sel1_i(s1), .en1_i(e1),
        .ign0_i(g0), .ign1_i(g1), .clk_o(out0)
    );

    // park high, input 1 preselected
    cmux_glitchfree #(.PARK_HIGH(1'b1), .PRESEL0(1'b0), .PRESEL1(1'b1)) u1 (
        .clk0_i(clk0), .clk1_i(clk1), .arst_ni(arst_n),
        .sel0_i(s0), .en0_i(e0), .sel1_i(s1), .en1_i(e1),
        .ign0_i(g0), .ign1_i(g1), .clk_o(out1)
    );

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- scoreboard ----------------
    typedef struct {
        int    src;   // 0, 1 or 2 = parked
        string tag;
    } item_t;

    item_t q[$];
    bit    mon_busy = 1'b0;

    initial begin
        forever begin
            item_t it;
            wait (q.size() > 0);
            mon_busy = 1'b1;
            it = q.pop_front();
            if (it.src == 0) begin
                @(posedge clk0); #1.0;
                check(out0 == 1'b1, {it.tag, " u0 high phase of clk0"}, out0, 1);
                check(out1 == 1'b1, {it.tag, " u1 high phase of clk0"}, out1, 1);
                @(negedge clk0); #1.0;
                check(out0 == 1'b0, {it.tag, " u0 low phase of clk0"}, out0, 0);
                check(out1 == 1'b0, {it.tag, " u1 low phase of clk0"}, out1, 0);
            end else if (it.src == 1) begin
                @(posedge clk1); #1.7;
                check(out0 == 1'b1, {it.tag, " u0 high phase of clk1"}, out0, 1);
                check(out1 == 1'b1, {it.tag, " u1 high phase of clk1"}, out1, 1);
                @(negedge clk1); #1.7;
                check(out0 == 1'b0, {it.tag, " u0 low phase of clk1"}, out0, 0);
                check(out1 == 1'b0, {it.tag, " u1 low phase of clk1"}, out1, 0);
            end else begin
                @(posedge clk0); #1.0;
                check(out0 == 1'b0, {it.tag, " R7 u0 parked low"}, out0, 0);
                check(out1 == 1'b1, {it.tag, " R7 R4 u1 parked high"}, out1, 1);
                @(negedge clk1); #1.7;
                check(out0 == 1'b0, {it.tag, " R7 u0 parked low"}, out0, 0);
                check(out1 == 1'b1, {it.tag, " R7 R4 u1 parked high"}, out1, 1);
            end
            mon_busy = 1'b0;
        end
    end

    // expected source from the request rules (R1, R9)
    function automatic int exp_src(input logic a, input logic b, input logic c, input logic d);
        if (a & b) return 0;
        if (c & d) return 1;
        return 2;
    endfunction

    task automatic apply(input logic a, input logic b, input logic c, input logic d,
                         input string tag);
        item_t it;
        {s0, e0, s1, e1} = {a, b, c, d};
        #80;
        it.src = exp_src(a, b, c, d);
        it.tag = tag;
        q.push_back(it);
        #1;
        wait (q.size() == 0 && !mon_busy);
    endtask

    // ---------------- pulse width monitor (R10, R2, R4) ----------------
    bit  pulse_en = 1'b0;
    real last0 = 0.0, last1 = 0.0;
    real min0 = 1.0e9, min1 = 1.0e9;
    bit  arm0 = 1'b0, arm1 = 1'b0;

    always @(out0) begin
        if (pulse_en && arm0 && ($realtime - last0) < min0) min0 = $realtime - last0;
        last0 = $realtime;
        arm0  = pulse_en;
    end

    always @(out1) begin
        if (pulse_en && arm1 && ($realtime - last1) < min1) min1 = $realtime - last1;
        last1 = $realtime;
        arm1  = pulse_en;
    end

    // ---------------- driver ----------------
    initial begin
        // R6: during reset each instance follows its preselected input
        #20;
        @(posedge clk0); #1.0;
        check(out0 == 1'b1, "R6 reset u0 follows clk0 high", out0, 1);
        @(negedge clk0); #1.0;
        check(out0 == 1'b0, "R6 reset u0 follows clk0 low", out0, 0);
        @(posedge clk1); #1.7;
        check(out1 == 1'b1, "R6 reset u1 follows clk1 high", out1, 1);
        @(negedge clk1); #1.7;
        check(out1 == 1'b0, "R6 reset u1 follows clk1 low", out1, 0);

        {s0, e0} = 2'b11;
        #0.3 arst_n = 1'b1;
        apply(1, 1, 0, 0, "R6 after release on input 0");
        pulse_en = 1'b1;

        apply(0, 0, 1, 1, "R3 hand over to input 1");
        apply(1, 1, 0, 0, "R3 hand over to input 0");
        apply(1, 0, 0, 0, "R1 select only");
        apply(0, 1, 0, 0, "R1 enable only");
        apply(0, 0, 0, 0, "R7 nothing requested");
        apply(0, 0, 1, 0, "R1 select1 only");
        apply(0, 0, 1, 1, "R3 from park to input 1");
        apply(1, 1, 1, 1, "R9 both requested");
        apply(0, 1, 1, 1, "R1 R9 input 0 half asserted");

        // R2: without ignore a drop in the high phase does not cut the pulse
        apply(1, 1, 0, 0, "R2 setup");
        @(posedge clk0); #0.5;
        s0 = 1'b0;
        #0.2;
        check(out0 == 1'b1, "R2 u0 keeps high phase after drop", out0, 1);
        apply(1, 1, 0, 0, "R2 restore");

        // R5: ignore flags release at once
        pulse_en = 1'b0;
        g0 = 1'b1;
        @(posedge clk0); #0.5;
        s0 = 1'b0;
        #0.2;
        check(out0 == 1'b0, "R5 ign0 u0 leaves in high phase", out0, 0);
        s0 = 1'b1;
        #80;
        @(negedge clk0); #0.5;
        s0 = 1'b0;
        #0.2;
        check(out1 == 1'b1, "R5 ign0 u1 leaves in low phase", out1, 1);
        g0 = 1'b0;
        apply(0, 0, 1, 1, "R5 setup input 1");
        g1 = 1'b1;
        @(posedge clk1); #0.5;
        s1 = 1'b0;
        #0.2;
        check(out0 == 1'b0, "R5 ign1 u0 leaves in high phase", out0, 0);
        g1 = 1'b0;
        apply(0, 0, 0, 0, "R7 after ignore");
        pulse_en = 1'b1;

        // R10: request changes at random times
        for (int k = 0; k < 40; k++) begin
            logic [3:0] r;
            r = 4'($urandom_range(0, 15));
            #($urandom_range(0, 70) / 10.0);
            apply(r[3], r[2], r[1], r[0], "R10 random pattern");
        end

        check(min0 >= 1.999, "R10 R2 R3 u0 shortest pulse (ps)", int'(min0 * 1000.0), 2000);
        check(min1 >= 1.999, "R10 R4 u1 shortest pulse (ps)", int'(min1 * 1000.0), 2000);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule